// File: doc/BRIEF.md
# Third-Order Sinc Decimator for a One-Bit Sigma-Delta Stream

This block turns the single-bit output of a sigma-delta modulator into 16-bit two's complement samples. Each accepted input bit counts as +1 (bit high) or −1 (bit low). Three cascaded integrators run once per accepted bit. Three comb stages run once per output sample. Together they give the response ((1 − z^-N)/(1 − z^-1))^3, with the decimation ratio N chosen from four values.

The internal result grows by 3·log2(N) bits. For N = 32 that is 15 bits, and for N = 256 it is 24 bits. The block aligns this result into a fixed 16-bit word:
- At the lowest ratio the full result is kept.
- At higher ratios the low bits are dropped.
- In mixed control/data mode the top bit of the word is a flag and the sample keeps 15 bits.

A settled indicator marks samples whose filter window lies wholly after the last reset or rate change.

Top module: `cic3_decimator`

## Requirements
- R1: `rate_sel` values 0, 1, 2 and 3 select N = 32, 64, 128 and 256. `sample_valid` pulses high for exactly one clock after every N accepted bits, and an accepted bit is one with `bit_en` high.
- R2: While `bit_en` is low, `bit_in` has no effect on the filter state and causes no sample.
- R3: With `mixed_mode` low, let y be the filter result, where a bit high counts +1 and a bit low counts −1. The output is floor(y / 2^(3·log2(N) − 15)) in two's complement. At N = 32 the full result is output unchanged, and its LSB is zero.
- R4: For an input that repeats with period N and has p ones per period, every settled sample equals the formatted value of y = N²·(2p − N).
- R5: The positive full-scale result is clamped to 0x7FFF. The negative full-scale result gives 0x8000.
- R6: With `mixed_mode` high, bit 15 of the output is the flag and is 0 for data. Bits 14:0 hold floor(y / 2^(3·log2(N) − 14)), clamped to at most 16383.
- R7: `sample_settled` is low for the first three samples after reset or after a change of `rate_sel`, and high from the fourth sample on.
- R8: A change of `rate_sel` clears all integrator, comb and counter state. The fourth sample after the change is correct for the new ratio.
- R9: While reset is high and after it is released, `sample_out`, `sample_valid` and `sample_settled` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies `bit_in` as one modulator bit |
| bit_in | input | 1 | Modulator bit: 1 counts +1, 0 counts −1 |
| rate_sel | input | 2 | Decimation ratio select: N = 32 << rate_sel |
| mixed_mode | input | 1 | 1 selects the 15-bit sample with a flag in bit 15 |
| sample_out | output | 16 | Formatted two's complement sample |
| sample_valid | output | 1 | One-clock strobe for a new sample |
| sample_settled | output | 1 | The sample's window is fully past the last flush |

## Verification
The bench builds the block with its default parameters. These give four ratios from 32 to 256 and a 26-bit accumulator. The runs are short enough to sweep every ratio in both output modes.

For each setting the bench applies periodic bit patterns whose settled output is N²·(2p − N) whatever the filter's delay. It sweeps p over the full range, including both full-scale ends. Within these runs it:
- checks every sample value arithmetically, with and without gaps in `bit_en`;
- measures the strobe spacing;
- checks the settled flag;
- changes the rate without a reset, to exercise the flush.

// File: rtl/cic3_pkg.sv
package cic3_pkg;
  localparam int RATE_W    = 2;
  localparam int MIN_LOG2  = 5;
  localparam int NUM_RATES = 1 << RATE_W;
  localparam int MAX_LOG2  = MIN_LOG2 + NUM_RATES - 1;
  localparam int ORDER     = 3;
  localparam int ACC_W     = ORDER * MAX_LOG2 + 2;
  localparam int OUT_W     = 16;
  localparam int LG_W      = 4;
endpackage

// File: rtl/cic3_integ.sv
module cic3_integ #(
  parameter int W     = 26,
  parameter int ORDER = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                en,
  input  logic signed [W-1:0] x,
  output logic signed [W-1:0] acc
);
  for (genvar s = 0; s < ORDER; s++) begin : g_stage
    logic signed [W-1:0] src;
    logic signed [W-1:0] acc_r;
    if (s == 0) begin : g_first
      assign src = x;
    end else begin : g_next
      assign src = g_stage[s-1].acc_r;
    end
    // Modular sums; wrap-around is cancelled by the combs.
    always_ff @(posedge clk) begin
      if (rst || clr) acc_r <= '0;
      else if (en)    acc_r <= acc_r + src;
    end
  end

  assign acc = g_stage[ORDER-1].acc_r;
endmodule

// File: rtl/cic3_comb.sv
module cic3_comb #(
  parameter int W     = 26,
  parameter int ORDER = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                tick,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] dout
);
  for (genvar s = 0; s < ORDER; s++) begin : g_stage
    logic signed [W-1:0] src;
    logic signed [W-1:0] dly_r;
    logic signed [W-1:0] diff;
    if (s == 0) begin : g_first
      assign src = din;
    end else begin : g_next
      assign src = g_stage[s-1].diff;
    end
    assign diff = src - dly_r;
    always_ff @(posedge clk) begin
      if (rst || clr) dly_r <= '0;
      else if (tick)  dly_r <= src;
    end
  end

  assign dout = g_stage[ORDER-1].diff;
endmodule

// File: rtl/cic3_format.sv
module cic3_format
  import cic3_pkg::*;
#(
  parameter int W = ACC_W
) (
  input  logic signed [W-1:0]     y,
  input  logic [LG_W-1:0]         lg2,
  input  logic                    mixed,
  output logic [OUT_W-1:0]        word
);
  localparam int SH_W = 5;
  localparam int FULL_MAX  = (1 << (OUT_W - 1)) - 1;
  localparam int MIXED_MAX = (1 << (OUT_W - 2)) - 1;

  logic [SH_W-1:0]     sh;
  logic signed [W-1:0] scaled;
  logic signed [W-1:0] lim;
  logic [OUT_W-1:0]    sat;

  always_comb begin
    // Growth is 3*lg2 bits; keep OUT_W-1 (or OUT_W-2 in mixed) below sign.
    sh     = SH_W'(ORDER * int'(lg2) - (OUT_W - 1) + int'(mixed));
    scaled = y >>> sh;
    lim    = mixed ? W'(MIXED_MAX) : W'(FULL_MAX);
    sat    = (scaled > lim) ? lim[OUT_W-1:0] : scaled[OUT_W-1:0];
    word   = mixed ? {1'b0, sat[OUT_W-2:0]} : sat;
  end
endmodule

// File: rtl/cic3_decimator.sv
module cic3_decimator
  import cic3_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              mixed_mode,
  output logic [OUT_W-1:0]  sample_out,
  output logic              sample_valid,
  output logic              sample_settled
);
  localparam int CNT_W    = MAX_LOG2;
  localparam int SETTLE_N = ORDER;
  localparam int SC_W     = $clog2(SETTLE_N + 1);

  logic [RATE_W-1:0]       rate_q;
  logic [LG_W-1:0]         lg2;
  logic [CNT_W:0]          n_val;
  logic [CNT_W-1:0]        dcnt;
  logic                    flush, step, last, tick;
  logic signed [ACC_W-1:0] x, integ_out, comb_out;
  logic [OUT_W-1:0]        fmt_word;
  logic [SC_W-1:0]         scnt;

  assign flush = (rate_sel != rate_q);
  assign lg2   = LG_W'(MIN_LOG2) + LG_W'(rate_q);
  assign n_val = (CNT_W+1)'(1) << lg2;
  assign step  = bit_en && !flush;
  assign last  = ({1'b0, dcnt} == n_val - 1'b1);
  assign tick  = step && last;
  assign x     = bit_in ? ACC_W'(1) : '1;

  always_ff @(posedge clk) begin
    if (rst) rate_q <= rate_sel;
    else     rate_q <= rate_sel;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) dcnt <= '0;
    else if (step)    dcnt <= last ? '0 : dcnt + 1'b1;
  end

  cic3_integ #(.W(ACC_W), .ORDER(ORDER)) u_integ (
    .clk(clk), .rst(rst), .clr(flush), .en(step), .x(x), .acc(integ_out)
  );

  cic3_comb #(.W(ACC_W), .ORDER(ORDER)) u_comb (
    .clk(clk), .rst(rst), .clr(flush), .tick(tick), .din(integ_out), .dout(comb_out)
  );

  cic3_format #(.W(ACC_W)) u_fmt (
    .y(comb_out), .lg2(lg2), .mixed(mixed_mode), .word(fmt_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_out     <= '0;
      sample_valid   <= 1'b0;
      sample_settled <= 1'b0;
      scnt           <= '0;
    end else if (flush) begin
      sample_valid   <= 1'b0;
      sample_settled <= 1'b0;
      scnt           <= '0;
    end else begin
      sample_valid <= tick;
      if (tick) begin
        sample_out     <= fmt_word;
        sample_settled <= (scnt == SC_W'(SETTLE_N));
        if (scnt != SC_W'(SETTLE_N)) scnt <= scnt + 1'b1;
      end
    end
  end

  // R1
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> !sample_valid);

  // R1
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, dcnt} < n_val));

  // R6
  mixed_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && mixed_mode) |=> (sample_valid && !sample_out[OUT_W-1]));

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rate_sel != rate_q) |=> (!sample_settled && !sample_valid && dcnt == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!bit_en && !flush) |=> ($stable(dcnt) && $stable(integ_out) && !sample_valid));
endmodule

// File: tb/sim_cic3_decimator.sv
`timescale 1ns/1ps
module sim_cic3_decimator;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_en = 1'b0;
  logic        bit_in = 1'b0;
  logic [1:0]  rate_sel = 2'd0;
  logic        mixed_mode = 1'b0;
  logic [15:0] sample_out;
  logic        sample_valid;
  logic        sample_settled;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cic3_decimator u0 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
    .rate_sel(rate_sel), .mixed_mode(mixed_mode),
    .sample_out(sample_out), .sample_valid(sample_valid),
    .sample_settled(sample_settled)
  );

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Settled value of a period-N pattern with p ones: y = N^2 (2p - N).
  function automatic longint expect_word(int rs, bit mx, int p);
    longint n  = 64'(32) << rs;
    longint y  = n * n * (2 * p - n);
    int     sh = 3 * (5 + rs) - 15 + int'(mx);
    longint s  = y >>> sh;
    longint lim = mx ? 16383 : 32767;
    if (s > lim) s = lim;
    return mx ? (s & 64'h7FFF) : (s & 64'hFFFF);
  endfunction

  task automatic run_case(int rs, bit mx, int p, bit gap, bit do_reset);
    int n = 32 << rs;
    int samples = 0;
    int en_since = 0;
    int bitpos = 0;
    int cyc = 0;
    string tag_val;
    @(negedge clk);
    rate_sel   = 2'(rs);
    mixed_mode = mx;
    bit_en     = 1'b0;
    if (do_reset) begin
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
    end
    tag_val = mx ? "R6" : ((p == 0 || p == n) ? "R5" : (rs == 0 ? "R3" : "R4"));
    while (samples < 6 && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (sample_valid) begin
        samples++;
        if (samples > 1) check("R1 spacing", en_since, n);  // R2 when gap
        en_since = 0;
        check(do_reset ? "R7 settled" : "R8 settled", sample_settled, samples >= 4);
        if (samples >= 4) check(tag_val, sample_out, expect_word(rs, mx, p));
      end
      bit_en = gap ? (cyc % 3 != 0) : 1'b1;
      bit_in = (bitpos < p);
      if (gap && !bit_en) bit_in = ~bit_in;  // R2: ignored while not enabled
      if (bit_en) begin
        bitpos = (bitpos + 1) % n;
        en_since++;
      end
    end
    check("R1 sample count", samples, 6);
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 out", sample_out, 0);
    check("R9 valid", sample_valid, 0);
    check("R9 settled", sample_settled, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R9 out after release", sample_out, 0);

    // R2: toggling bit_in with bit_en low produces no sample
    begin
      int seen = 0;
      for (int i = 0; i < 600; i++) begin
        bit_in = i[0];
        @(negedge clk);
        if (sample_valid) seen++;
      end
      check("R2 no strobe", seen, 0);
    end

    for (int rs = 0; rs < 4; rs++) begin
      for (int m = 0; m < 2; m++) begin
        int n = 32 << rs;
        int plist[6] = '{0, 1, n / 4, n / 2, n - 1, n};
        for (int j = 0; j < 6; j++)
          run_case(rs, m[0], plist[j], j[0], 1'b1);
      end
    end

    // R8: rate changes without reset
    run_case(0, 1'b0, 8, 1'b0, 1'b1);
    run_case(3, 1'b0, 200, 1'b0, 1'b0);
    run_case(1, 1'b1, 10, 1'b1, 1'b0);
    run_case(2, 1'b0, 128, 1'b0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule